// File: doc/BRIEF.md
# Three-Bus Single-Cycle Register Processor

This block is a minimal processor core. It runs one instruction every clock cycle. It has eight 8-bit general registers, an 8-bit program counter, an ALU and two condition flags: negative (N) and zero (Z). The core puts its program counter on the fetch address. The instruction memory returns the instruction word combinationally in the same cycle. The core decodes the word and reads two source registers onto two separate read buses. The ALU combines the two bus values. The result travels on a single write bus back to the destination register. The same clock edge then loads the next program counter: either the incremented value or the branch target.

Every operand comes from a register. There is no immediate form and no data memory, so a program builds its constants from the zero state that reset leaves behind. For example, the inverse of zero gives 0xFF, and subtracting that from zero gives 1.

The write bus is brought out on the ports as plain signals, valid only within the cycle that drives them. This lets the surrounding logic observe each result. Neither the fetch path nor the write-bus observation carries a valid/ready handshake. The core consumes one instruction in every cycle and never stalls, so there is no back-pressure to express.

Top module: `tri_bus_core`

## Requirements
- R1: The fetch address always equals the program counter. The 21-bit instruction word is laid out as opcode [20:17], first source [16:14], second source [13:11], destination [10:8] and branch target [7:0]. Each register field selects exactly one of the eight registers.
- R2: A synchronous reset, sampled on the clock edge, clears the program counter, all eight registers and both flags to 0.
- R3: The register operations are: opcode 0 copies source 1; opcode 1 adds the sources; opcode 2 subtracts source 2 from source 1; opcode 3 is bitwise AND; opcode 4 is bitwise OR; opcode 5 inverts source 1. Each result is taken modulo 256, appears on the write bus in the executing cycle, and is written to the destination at the closing edge.
- R4: Each of opcodes 0 to 5 sets N to bit 7 of its result and sets Z to 1 exactly when the result is zero.
- R5: Opcode 6 loads the target when N is 1. Opcode 7 loads the target when Z is 1. Opcode 8 always loads the target. In every other case the program counter advances by one.
- R6: Branch opcodes and no-op opcodes leave all registers and both flags unchanged, whatever their register fields hold.
- R7: Opcodes 9 to 15 do nothing except advance the program counter by one.
- R8: The program counter wraps from 255 to 0.
- R9: An instruction reads the value written by the instruction before it. Both source fields may name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Fetch address (current program counter) |
| imem_data | input | 21 | Instruction word at imem_addr, combinational |
| wr_en | output | 1 | Write bus carries a register result this cycle |
| wr_dst | output | 3 | Destination register index on the write bus |
| wr_data | output | 8 | Write bus value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The assertions assume two things about the inputs. First, the instruction word is a known value in every cycle after reset. Second, reset is held through at least one rising edge before it is released. The bench meets both conditions. It fills the whole 256-word program store with a defined no-op before each scenario and then writes only the words that scenario needs. It changes reset and the program only on falling edges, and it asserts reset for two edges at the start of each scenario. Because the program store covers every fetch address, the wrap from 255 to 0 still fetches defined words.

// File: rtl/tbc_pkg.sv
`timescale 1ns/1ps
package tbc_pkg;
  localparam int DATA_W  = 8;
  localparam int PC_W    = 8;
  localparam int REG_N   = 8;
  localparam int SEL_W   = $clog2(REG_N);
  localparam int OP_W    = 4;
  localparam int INSTR_W = OP_W + 3 * SEL_W + PC_W;

  localparam logic [OP_W-1:0] OP_MOV = 4'd0;
  localparam logic [OP_W-1:0] OP_ADD = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB = 4'd2;
  localparam logic [OP_W-1:0] OP_AND = 4'd3;
  localparam logic [OP_W-1:0] OP_OR  = 4'd4;
  localparam logic [OP_W-1:0] OP_INV = 4'd5;
  localparam logic [OP_W-1:0] OP_BRN = 4'd6;
  localparam logic [OP_W-1:0] OP_BRZ = 4'd7;
  localparam logic [OP_W-1:0] OP_JMP = 4'd8;

  typedef enum logic [2:0] {
    FN_PASS, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_INV
  } alu_fn_t;

  typedef enum logic [1:0] {
    NX_STEP, NX_IF_NEG, NX_IF_ZERO, NX_ALWAYS
  } next_mode_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dst;
    logic [PC_W-1:0]  tgt;
  } instr_t;
endpackage

// File: rtl/tbc_decode.sv
`timescale 1ns/1ps
module tbc_decode
  import tbc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  instr_t           ins,
  output logic [REG_N-1:0] rd_a_sel,
  output logic [REG_N-1:0] rd_b_sel,
  output logic [REG_N-1:0] wr_sel,
  output logic             wr_en,
  output alu_fn_t          fn,
  output next_mode_t       nx_mode
);
  // one-hot field decoders, one line per register
  for (genvar g = 0; g < REG_N; g++) begin : g_onehot
    assign rd_a_sel[g] = (ins.src_a == SEL_W'(g));
    assign rd_b_sel[g] = (ins.src_b == SEL_W'(g));
    assign wr_sel[g]   = wr_en && (ins.dst == SEL_W'(g));
  end

  always_comb begin
    wr_en   = 1'b0;
    fn      = FN_PASS;
    nx_mode = NX_STEP;
    unique case (ins.op)
      OP_MOV: begin wr_en = 1'b1; fn = FN_PASS; end
      OP_ADD: begin wr_en = 1'b1; fn = FN_ADD;  end
      OP_SUB: begin wr_en = 1'b1; fn = FN_SUB;  end
      OP_AND: begin wr_en = 1'b1; fn = FN_AND;  end
      OP_OR:  begin wr_en = 1'b1; fn = FN_OR;   end
      OP_INV: begin wr_en = 1'b1; fn = FN_INV;  end
      OP_BRN: nx_mode = NX_IF_NEG;
      OP_BRZ: nx_mode = NX_IF_ZERO;
      OP_JMP: nx_mode = NX_ALWAYS;
      default: ;
    endcase
  end

  // R7
  noop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ins.op > OP_JMP) |-> (!wr_en && nx_mode == NX_STEP && wr_sel == '0));
  // R1
  src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(rd_a_sel) && $onehot(rd_b_sel));
endmodule

// File: rtl/tbc_regfile.sv
`timescale 1ns/1ps
module tbc_regfile
  import tbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_N-1:0]  rd_a_sel,
  input  logic [REG_N-1:0]  rd_b_sel,
  input  logic [REG_N-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_bus,
  output logic [DATA_W-1:0] bus_a,
  output logic [DATA_W-1:0] bus_b
);
  logic [DATA_W-1:0] rf [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            rf[g] <= '0;
      else if (wr_sel[g]) rf[g] <= wr_bus;
    end

    // R3
    reg_load_chk: assert property (@(posedge clk) disable iff (rst)
      wr_sel[g] |=> (rf[g] == $past(wr_bus)));
    // R6
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[g] |=> $stable(rf[g]));
  end

  // gated-OR read buses: each selected register drives its bus lane
  always_comb begin
    bus_a = '0;
    bus_b = '0;
    for (int i = 0; i < REG_N; i++) begin
      bus_a = bus_a | (rf[i] & {DATA_W{rd_a_sel[i]}});
      bus_b = bus_b | (rf[i] & {DATA_W{rd_b_sel[i]}});
    end
  end

  // R1
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));
endmodule

// File: rtl/tbc_alu.sv
`timescale 1ns/1ps
module tbc_alu
  import tbc_pkg::*;
(
  input  alu_fn_t           fn,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              neg,
  output logic              zero
);
  always_comb begin
    unique case (fn)
      FN_PASS: y = a;
      FN_ADD:  y = a + b;
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_INV:  y = ~a;
      default: y = a;
    endcase
  end

  assign neg  = y[DATA_W-1];
  assign zero = (y == '0);
endmodule

// File: rtl/tbc_pc.sv
`timescale 1ns/1ps
module tbc_pc
  import tbc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  next_mode_t      nx_mode,
  input  logic            flag_n,
  input  logic            flag_z,
  input  logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] pc
);
  logic            take;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc + PC_W'(1);

  always_comb begin
    unique case (nx_mode)
      NX_IF_NEG:  take = flag_n;
      NX_IF_ZERO: take = flag_z;
      NX_ALWAYS:  take = 1'b1;
      default:    take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (take) pc <= tgt;
    else           pc <= pc_inc;
  end

  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (nx_mode == NX_STEP) |=> (pc == $past(pc) + PC_W'(1)));
  // R5
  jump_chk: assert property (@(posedge clk) disable iff (rst)
    (nx_mode == NX_ALWAYS) |=> (pc == $past(tgt)));
  // R5
  neg_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (nx_mode == NX_IF_NEG && flag_n) |=> (pc == $past(tgt)));
endmodule

// File: rtl/tri_bus_core.sv
`timescale 1ns/1ps
module tri_bus_core
  import tbc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_data,
  output logic               wr_en,
  output logic [SEL_W-1:0]   wr_dst,
  output logic [DATA_W-1:0]  wr_data,
  output logic               flag_n,
  output logic               flag_z
);
  instr_t            ins;
  logic [REG_N-1:0]  rd_a_sel, rd_b_sel, wr_sel;
  alu_fn_t           fn;
  next_mode_t        nx_mode;
  logic [DATA_W-1:0] bus_a, bus_b, wbus;
  logic              res_neg, res_zero;
  logic [PC_W-1:0]   pc;

  assign ins       = instr_t'(imem_data);
  assign imem_addr = pc;

  tbc_decode u_dec (
    .clk(clk), .rst(rst), .ins(ins),
    .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel), .wr_sel(wr_sel),
    .wr_en(wr_en), .fn(fn), .nx_mode(nx_mode)
  );

  tbc_regfile u_rf (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel), .wr_sel(wr_sel),
    .wr_bus(wbus), .bus_a(bus_a), .bus_b(bus_b)
  );

  tbc_alu u_alu (
    .fn(fn), .a(bus_a), .b(bus_b),
    .y(wbus), .neg(res_neg), .zero(res_zero)
  );

  tbc_pc u_pc (
    .clk(clk), .rst(rst), .nx_mode(nx_mode),
    .flag_n(flag_n), .flag_z(flag_z), .tgt(ins.tgt), .pc(pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (wr_en) begin
      flag_n <= res_neg;
      flag_z <= res_zero;
    end
  end

  assign wr_dst  = ins.dst;
  assign wr_data = wbus;

  // R4
  flag_track_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flag_n == $past(wr_data[DATA_W-1]) && flag_z == ($past(wr_data) == '0)));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(flag_n) && $stable(flag_z)));
  // R1
  fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
    imem_addr == pc);
endmodule

// File: tb/tb_tri_bus_core.sv
`timescale 1ns/1ps
module tb_tri_bus_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imem_addr;
  logic [20:0] imem_data;
  logic        wr_en;
  logic [2:0]  wr_dst;
  logic [7:0]  wr_data;
  logic        flag_n, flag_z;
  logic [20:0] prog [256];
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  assign imem_data = prog[imem_addr];

  tri_bus_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  function automatic logic [20:0] enc(input logic [3:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [2:0] d,
                                      input logic [7:0] t);
    return {op, a, b, d, t};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = enc(4'd9, 3'd0, 3'd0, 3'd2, 8'd0);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // at a falling edge: check fetch address and write bus, then move one cycle
  task automatic step(input string tag, input logic [7:0] pc, input logic wen,
                      input logic [2:0] dst, input logic [7:0] data);
    check({tag, " pc"}, 32'(imem_addr), 32'(pc));
    check({tag, " wr_en"}, 32'(wr_en), 32'(wen));
    if (wen) begin
      check({tag, " wr_dst"}, 32'(wr_dst), 32'(dst));
      check({tag, " wr_data"}, 32'(wr_data), 32'(data));
    end
    @(negedge clk);
  endtask

  task automatic flags(input string tag, input logic n, input logic z);
    check({tag, " N"}, 32'(flag_n), 32'(n));
    check({tag, " Z"}, 32'(flag_z), 32'(z));
  endtask

  task automatic test_alu();
    clear_prog();
    prog[0]  = enc(4'd5, 3'd0, 3'd0, 3'd1, 8'd0);
    prog[1]  = enc(4'd2, 3'd0, 3'd1, 3'd2, 8'd0);
    prog[2]  = enc(4'd1, 3'd2, 3'd2, 3'd3, 8'd0);
    prog[3]  = enc(4'd1, 3'd3, 3'd2, 3'd4, 8'd0);
    prog[4]  = enc(4'd3, 3'd4, 3'd3, 3'd5, 8'd0);
    prog[5]  = enc(4'd4, 3'd5, 3'd2, 3'd6, 8'd0);
    prog[6]  = enc(4'd0, 3'd1, 3'd0, 3'd7, 8'd0);
    prog[7]  = enc(4'd2, 3'd2, 3'd2, 3'd0, 8'd0);
    prog[8]  = enc(4'd1, 3'd1, 3'd2, 3'd1, 8'd0);
    prog[9]  = enc(4'd0, 3'd7, 3'd0, 3'd5, 8'd0);
    prog[10] = enc(4'd0, 3'd1, 3'd0, 3'd6, 8'd0);
    do_reset();
    flags("R2 reset flags", 1'b0, 1'b0);
    step("R3 inv",  8'd0, 1'b1, 3'd1, 8'hFF); flags("R4 inv", 1'b1, 1'b0);
    step("R3 sub",  8'd1, 1'b1, 3'd2, 8'h01); flags("R4 sub", 1'b0, 1'b0);
    step("R9 add same src", 8'd2, 1'b1, 3'd3, 8'h02);
    step("R3 add",  8'd3, 1'b1, 3'd4, 8'h03);
    step("R3 and",  8'd4, 1'b1, 3'd5, 8'h02);
    step("R3 or",   8'd5, 1'b1, 3'd6, 8'h03);
    step("R3 mov",  8'd6, 1'b1, 3'd7, 8'hFF); flags("R4 mov neg", 1'b1, 1'b0);
    step("R3 sub zero", 8'd7, 1'b1, 3'd0, 8'h00); flags("R4 zero", 1'b0, 1'b1);
    step("R3 add wrap", 8'd8, 1'b1, 3'd1, 8'h00); flags("R4 wrap zero", 1'b0, 1'b1);
    step("R9 read r7",  8'd9, 1'b1, 3'd5, 8'hFF);
    step("R9 read r1",  8'd10, 1'b1, 3'd6, 8'h00);
  endtask

  task automatic test_reset_clears();
    // registers hold nonzero values and Z is 1 from test_alu
    clear_prog();
    prog[0] = enc(4'd0, 3'd4, 3'd0, 3'd3, 8'd0);
    prog[1] = enc(4'd0, 3'd7, 3'd0, 3'd3, 8'd0);
    do_reset();
    flags("R2 flags cleared", 1'b0, 1'b0);
    step("R2 r4 cleared", 8'd0, 1'b1, 3'd3, 8'h00);
    step("R2 r7 cleared", 8'd1, 1'b1, 3'd3, 8'h00);
  endtask

  task automatic test_branch();
    clear_prog();
    prog[0]  = enc(4'd5, 3'd0, 3'd0, 3'd1, 8'd0);
    prog[1]  = enc(4'd6, 3'd1, 3'd1, 3'd2, 8'd5);
    prog[5]  = enc(4'd2, 3'd0, 3'd1, 3'd2, 8'd0);
    prog[6]  = enc(4'd6, 3'd0, 3'd0, 3'd2, 8'd20);
    prog[7]  = enc(4'd7, 3'd0, 3'd0, 3'd2, 8'd20);
    prog[8]  = enc(4'd2, 3'd2, 3'd2, 3'd3, 8'd0);
    prog[9]  = enc(4'd7, 3'd0, 3'd0, 3'd2, 8'd12);
    prog[12] = enc(4'd8, 3'd0, 3'd0, 3'd2, 8'd30);
    prog[30] = enc(4'd9, 3'd0, 3'd0, 3'd2, 8'd0);
    prog[31] = enc(4'd15, 3'd7, 3'd7, 3'd2, 8'd0);
    prog[32] = enc(4'd0, 3'd2, 3'd0, 3'd4, 8'd0);
    do_reset();
    step("R3 inv", 8'd0, 1'b1, 3'd1, 8'hFF);
    step("R5 brn taken", 8'd1, 1'b0, 3'd0, 8'h00);
    flags("R6 brn keeps flags", 1'b1, 1'b0);
    step("R5 target reached", 8'd5, 1'b1, 3'd2, 8'h01);
    step("R5 brn not taken", 8'd6, 1'b0, 3'd0, 8'h00);
    step("R5 brz not taken", 8'd7, 1'b0, 3'd0, 8'h00);
    step("R3 sub zero", 8'd8, 1'b1, 3'd3, 8'h00);
    step("R5 brz taken", 8'd9, 1'b0, 3'd0, 8'h00);
    step("R5 jmp", 8'd12, 1'b0, 3'd0, 8'h00);
    step("R7 noop 9", 8'd30, 1'b0, 3'd0, 8'h00);
    flags("R6 noop keeps flags", 1'b0, 1'b1);
    step("R7 noop 15", 8'd31, 1'b0, 3'd0, 8'h00);
    flags("R7 noop keeps flags", 1'b0, 1'b1);
    step("R6 r2 untouched", 8'd32, 1'b1, 3'd4, 8'h01);
  endtask

  task automatic test_wrap();
    clear_prog();
    prog[0]   = enc(4'd8, 3'd0, 3'd0, 3'd0, 8'd255);
    prog[255] = enc(4'd12, 3'd0, 3'd0, 3'd0, 8'd0);
    prog[1]   = enc(4'd5, 3'd0, 3'd0, 3'd0, 8'd0);
    do_reset();
    step("R5 jmp to end", 8'd0, 1'b0, 3'd0, 8'h00);
    step("R8 last address", 8'd255, 1'b0, 3'd0, 8'h00);
    step("R8 wrapped", 8'd0, 1'b0, 3'd0, 8'h00);
    step("R8 after wrap", 8'd255, 1'b0, 3'd0, 8'h00);
    check("R1 fetch addr after wrap", 32'(imem_addr), 32'd0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    clear_prog();
    test_alu();
    test_reset_clears();
    test_branch();
    test_wrap();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule